// File: doc/BRIEF.md
# Biphase IR Frame Transmitter

This block sends a remote-control code as a repeating, biphase-coded infrared frame. A scan controller hands it a 5-bit system number and a 6-bit command number together with a one-cycle ready strobe. The controller also supplies a flag that stays high while a key is held. Each frame carries two start ones, a toggle bit, the system field and the command field. The block drives an unmodulated data line and a copy of that line gated by a carrier. Both lines are released (output enables low) when the block is quiescent.

While the key stays held, frames repeat on a fixed period counted from the start of each frame. A frame that has begun always runs to its end. A release between frames returns the block to idle at once. The toggle bit flips on each return to idle that follows a finished frame, so a receiver can tell a fresh key press from a held one.

All timing is counted in oscillator clock cycles. One half-bit is `HALF_CYC` cycles, 384 by default, which gives a bit of 3·2^8 cycles. The frame period is `REP_BITS` bit-times, 64 by default. The carrier period is `CAR_DIV` cycles, 12 by default.

Top module: `biphase_ir_tx`

## Requirements
- R1: After reset and whenever idle, `data_en` and `mod_en` are low, and `data_out` and `mod_out` are low. The toggle bit resets to 0.
- R2: A frame is 14 bits sent in this order: 1, 1, toggle, system bits 4 down to 0, command bits 5 down to 0.
- R3: Each bit lasts 2·HALF_CYC cycles and is biphase coded. A 1 is low for the first half and high for the second. A 0 is high for the first half and low for the second.
- R4: In idle, a cycle with both `ready` and `key_held` high starts a frame on the next clock edge, using that cycle's `sys_num` and `cmd_num`. `key_held` without `ready` starts nothing.
- R5: While `key_held` stays high, a new frame starts exactly 2·HALF_CYC·REP_BITS cycles after the previous one. Between frames, both enables stay high and `data_out` is low.
- R6: Once started, a frame runs all 28 half-bits to the end even if `key_held` falls during it.
- R7: If `key_held` is low in a cycle between frames, both enables are low from the next clock edge.
- R8: The toggle bit is complemented on each return to idle after a finished frame. A press and release that sent no frame leaves it unchanged.
- R9: `mod_out` equals `data_out` AND a carrier of period CAR_DIV cycles. The carrier is high for the first CAR_DIV/2 cycles of each period, with the phase restarted at each frame start. `mod_en` follows `data_en`.
- R10: A repeated frame carries the fields of the most recent `ready` strobe. A strobe during a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_held | input | 1 | High while a key remains pressed |
| ready | input | 1 | One-cycle strobe: system and command numbers are valid |
| sys_num | input | 5 | System number |
| cmd_num | input | 6 | Command number |
| data_out | output | 1 | Unmodulated biphase data |
| data_en | output | 1 | Output enable of data_out (low = high impedance) |
| mod_out | output | 1 | Carrier-gated biphase data |
| mod_en | output | 1 | Output enable of mod_out (low = high impedance) |

## Verification
The checker watches several properties on every cycle:
- both lines are quiet in idle;
- the data line is held low between frames;
- the modulated line is never high while the data line is low;
- the data line stays level inside a half-bit;
- a frame in progress never drops to idle;
- a release between frames reaches idle in one cycle;
- the toggle bit changes only on a gap-to-idle step.

Only the bench's scenarios can show the rest:
- the exact field order and bit coding;
- the cycle at which each half-bit edge and each repetition lands;
- the carrier phase;
- the alternation of the toggle bit across presses;
- which latched fields a repeated frame carries.

// File: rtl/biphase_ir_tx.sv
module biphase_ir_tx #(
  parameter int HALF_CYC = 384,
  parameter int REP_BITS = 64,
  parameter int CAR_DIV  = 12,
  parameter int SYS_W    = 5,
  parameter int CMD_W    = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_held,
  input  logic             ready,
  input  logic [SYS_W-1:0] sys_num,
  input  logic [CMD_W-1:0] cmd_num,
  output logic             data_out,
  output logic             data_en,
  output logic             mod_out,
  output logic             mod_en
);
  localparam int FB     = 3 + SYS_W + CMD_W;
  localparam int FH     = 2 * FB;
  localparam int PERIOD = REP_BITS * 2 * HALF_CYC;
  localparam int HW     = $clog2(HALF_CYC + 1);
  localparam int XW     = $clog2(FH + 1);
  localparam int PW     = $clog2(PERIOD + 1);
  localparam int CW     = $clog2(CAR_DIV + 1);
  localparam logic [HW-1:0] H_LAST = HW'(HALF_CYC - 1);
  localparam logic [XW-1:0] X_LAST = XW'(FH - 1);
  localparam logic [PW-1:0] P_LAST = PW'(PERIOD - 1);
  localparam logic [CW-1:0] C_LAST = CW'(CAR_DIV - 1);
  localparam logic [CW-1:0] C_HALF = CW'(CAR_DIV / 2);

  typedef enum logic [1:0] {S_IDLE = 2'd0, S_SEND = 2'd1, S_GAP = 2'd2} st_t;

  st_t             state;
  logic [HW-1:0]   hcnt;
  logic [XW-1:0]   hidx;
  logic [PW-1:0]   pcnt;
  logic [CW-1:0]   ccnt;
  logic [FB-1:0]   shreg;
  logic            toggle_q;
  logic [SYS_W-1:0] nxt_sys;
  logic [CMD_W-1:0] nxt_cmd;

  wire last_half = (hcnt == H_LAST);
  wire frame_end = last_half && (hidx == X_LAST);
  wire [CW-1:0] car_next = (ccnt == C_LAST) ? '0 : ccnt + 1'b1;
  wire cur_bit = shreg[FB-1];

  assign data_en  = (state != S_IDLE);
  assign mod_en   = data_en;
  assign data_out = (state == S_SEND) && (hidx[0] ? cur_bit : ~cur_bit);
  assign mod_out  = data_out && (ccnt < C_HALF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      hcnt     <= '0;
      hidx     <= '0;
      pcnt     <= '0;
      ccnt     <= '0;
      shreg    <= '0;
      toggle_q <= 1'b0;
      nxt_sys  <= '0;
      nxt_cmd  <= '0;
    end else begin
      if (ready) begin
        nxt_sys <= sys_num;
        nxt_cmd <= cmd_num;
      end
      case (state)
        S_IDLE: if (key_held && ready) begin
          state <= S_SEND;
          hcnt  <= '0;
          hidx  <= '0;
          pcnt  <= '0;
          ccnt  <= '0;
          shreg <= {2'b11, toggle_q, sys_num, cmd_num};
        end
        S_SEND: begin
          pcnt <= pcnt + 1'b1;
          ccnt <= car_next;
          if (last_half) begin
            hcnt <= '0;
            hidx <= hidx + 1'b1;
            if (hidx[0]) shreg <= {shreg[FB-2:0], 1'b0};
            if (frame_end) state <= S_GAP;
          end else begin
            hcnt <= hcnt + 1'b1;
          end
        end
        S_GAP: begin
          if (!key_held) begin
            state    <= S_IDLE;
            toggle_q <= ~toggle_q;
          end else if (pcnt == P_LAST) begin
            state <= S_SEND;
            hcnt  <= '0;
            hidx  <= '0;
            pcnt  <= '0;
            ccnt  <= '0;
            shreg <= {2'b11, toggle_q, nxt_sys, nxt_cmd};
          end else begin
            pcnt <= pcnt + 1'b1;
            ccnt <= car_next;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ir_tx_checker.sv
module ir_tx_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       key_held,
  input logic       ready,
  input logic [1:0] st,
  input logic       last_half,
  input logic       tog,
  input logic       data_out,
  input logic       data_en,
  input logic       mod_out,
  input logic       mod_en
);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd0) |-> (!data_en && !mod_en && !data_out && !mod_out));

  a_r4_start: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd0 && ready && key_held) |=> (st == 2'd1 && data_en));

  a_r5_gap_low: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd2) |-> (data_en && !data_out));

  a_r3_half_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd1 && $past(st) == 2'd1 && !$past(last_half)) |-> $stable(data_out));

  a_r6_no_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd1) |=> (st != 2'd0));

  a_r7_release_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd2 && !key_held) |=> (!data_en && !mod_en));

  a_r8_toggle_when: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tog) |-> (st == 2'd0 && $past(st) == 2'd2));

  a_r9_mod_gated: assert property (@(posedge clk) disable iff (!rst_n)
    mod_out |-> (data_out && mod_en));
endmodule

bind biphase_ir_tx ir_tx_checker u_chk (
  .clk(clk), .rst_n(rst_n), .key_held(key_held), .ready(ready),
  .st(state), .last_half(last_half), .tog(toggle_q),
  .data_out(data_out), .data_en(data_en), .mod_out(mod_out), .mod_en(mod_en)
);

// File: tb/tb_biphase_ir_tx.sv
module tb_biphase_ir_tx;
  localparam int H   = 8;
  localparam int REP = 64;
  localparam int CD  = 12;
  localparam int FH  = 28;
  localparam int PER = REP * 2 * H;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic key_held = 1'b0;
  logic ready = 1'b0;
  logic [4:0] sys_num = '0;
  logic [5:0] cmd_num = '0;
  logic data_out, data_en, mod_out, mod_en;

  int total = 0;
  int fails = 0;
  logic exp_tog = 1'b0;

  always #5 clk = ~clk;

  biphase_ir_tx #(.HALF_CYC(H), .REP_BITS(REP), .CAR_DIV(CD)) dut (
    .clk(clk), .rst_n(rst_n), .key_held(key_held), .ready(ready),
    .sys_num(sys_num), .cmd_num(cmd_num),
    .data_out(data_out), .data_en(data_en), .mod_out(mod_out), .mod_en(mod_en));

  function automatic logic exp_data(logic [13:0] w, int i);
    int hf = i / H;
    logic v = w[13 - hf / 2];
    return (hf % 2 == 1) ? v : ~v;
  endfunction

  function automatic logic exp_car(int i);
    return (i % CD) < (CD / 2);
  endfunction

  task automatic chk(input bit ok, input string msg, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", msg, act, exp);
    end
  endtask

  task automatic press(input logic [4:0] s, input logic [5:0] c);
    key_held = 1'b1; ready = 1'b1; sys_num = s; cmd_num = c;
    @(negedge clk);
    ready = 1'b0;
  endtask

  task automatic observe(input logic [4:0] s, input logic [5:0] c, input logic t,
                         input int n, input int rel, input int rdy,
                         input logic [4:0] rs, input logic [5:0] rc, input string tag);
    logic [13:0] w;
    int idle_from;
    int bd = 0, bm = 0, be = 0;
    int fd = -1, fm = -1, fe = -1;
    w = {2'b11, t, s, c};
    if (rel < 0) idle_from = 1 << 30;
    else if (rel < FH * H) idle_from = FH * H + 1;
    else idle_from = rel + 1;
    for (int i = 0; i < n; i++) begin
      logic ee, ed, em;
      ee = (i < idle_from);
      ed = ee && (i < FH * H) && exp_data(w, i);
      em = ed && exp_car(i);
      if (data_out !== ed) begin bd++; if (fd < 0) fd = i; end
      if (mod_out !== em) begin bm++; if (fm < 0) fm = i; end
      if (data_en !== ee || mod_en !== ee) begin be++; if (fe < 0) fe = i; end
      if (i == rel) key_held = 1'b0;
      if (i == rdy) begin ready = 1'b1; sys_num = rs; cmd_num = rc; end
      else ready = 1'b0;
      @(negedge clk);
    end
    ready = 1'b0;
    chk(bd == 0, {tag, " R2 R3 data waveform, first bad cycle vs 0"}, fd, -1);
    chk(bm == 0, {tag, " R9 carrier gating, first bad cycle vs 0"}, fm, -1);
    chk(be == 0, {tag, " R5 R7 output enables, first bad cycle vs 0"}, fe, -1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", total, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234abcd));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!data_en && !mod_en, "R1 enables low after reset", {data_en, mod_en}, 0);
    chk(!data_out && !mod_out, "R1 outputs low after reset", {data_out, mod_out}, 0);

    key_held = 1'b1;
    begin
      int seen = 0;
      for (int i = 0; i < 20; i++) begin
        if (data_en) seen++;
        @(negedge clk);
      end
      chk(seen == 0, "R4 key without ready starts nothing", seen, 0);
    end
    key_held = 1'b0;
    repeat (3) @(negedge clk);

    press(5'h15, 6'h2A);
    observe(5'h15, 6'h2A, exp_tog, PER, -1, -1, '0, '0, "R4 first frame");
    observe(5'h15, 6'h2A, exp_tog, PER, -1, FH * H + 20, 5'h0A, 6'h15, "R5 repeat");
    observe(5'h0A, 6'h15, exp_tog, PER, -1, 30, 5'h1F, 6'h00, "R10 new fields");
    observe(5'h1F, 6'h00, exp_tog, FH * H + 4, 40, -1, '0, '0, "R6 R10 release in frame");
    exp_tog = ~exp_tog;
    repeat (3) @(negedge clk);

    press(5'h03, 6'h3F);
    observe(5'h03, 6'h3F, exp_tog, FH * H + 10, FH * H + 5, -1, '0, '0, "R8 R7 toggled, release in gap");
    exp_tog = ~exp_tog;
    repeat (3) @(negedge clk);

    key_held = 1'b1;
    repeat (10) @(negedge clk);
    key_held = 1'b0;
    repeat (3) @(negedge clk);
    press(5'h11, 6'h01);
    observe(5'h11, 6'h01, exp_tog, FH * H + 4, 10, -1, '0, '0, "R8 no flip without frame");
    exp_tog = ~exp_tog;
    repeat (3) @(negedge clk);

    for (int k = 0; k < 6; k++) begin
      logic [4:0] s;
      logic [5:0] c;
      int rel;
      s = 5'($urandom);
      c = 6'($urandom);
      rel = int'($urandom % (FH * H + 50));
      press(s, c);
      observe(s, c, exp_tog, FH * H + 60, rel, -1, '0, '0, "R2 R8 random");
      exp_tog = ~exp_tog;
      repeat (2 + ($urandom % 4)) @(negedge clk);
    end

    $display("  [TB] %0d tests run, %0d failed", total, fails);
    $finish;
  end
endmodule